// File: doc/BRIEF.md
# Single-Channel Block Transfer Engine with Cycle-Stealing and Burst Modes

This block moves a block of words between one I/O device and memory so that the processor does not have to handle each word. Software sets up the transfer first. It writes a first memory address, a number of words, and a control word that selects the direction, the bus-holding mode and whether an interrupt is raised. The control word also carries a start bit. Once started, the engine asks for the system bus with a request/grant handshake. In each cycle where it holds the grant and the device reports ready, it moves one word. For that word it drives the memory address and exactly one memory strobe, and it acknowledges the device.

There are two bus-holding modes. In cycle-stealing mode the engine hands the bus back for one cycle after every word, so the processor can use the bus between words. In burst mode it keeps the bus request up until the last word has moved. When the block is complete, the engine returns to idle and sets a done flag. If a start is given while the word count is zero, the engine moves nothing and sets an error flag instead. When the interrupt is enabled, either flag drives the interrupt line until software clears it. The system arbiter is expected to give this request precedence over the processor.

Top module: `dma_steal_ctrl`

## Requirements
- R1: After synchronous reset, bus_req, mem_rd, mem_wr, dev_ack and irq are 0, mem_addr, mem_wdata and dev_wdata are 0, and all four registers read back 0.
- R2: cfg_sel picks the register: 0 is the address, 1 is the remaining word count, 2 is control (bit 0 start, reads 0; bit 1 direction; bit 2 burst; bit 3 interrupt enable) and 3 is status (bit 0 busy, bit 1 done, bit 2 error). cfg_rdata shows the selected register in the same cycle. When the block is not busy, a write to select 0, 1 or 2 updates that register. While busy, writes to those three are ignored.
- R3: A start with a nonzero count raises bus_req in the following cycle. mem_rd, mem_wr and dev_ack are never high while bus_gnt is low.
- R4: A word moves only in a cycle where bus_req, bus_gnt and dev_ready are all high. In that cycle dev_ack is 1 and mem_addr equals the current address register. In every other cycle mem_addr is 0.
- R5: With direction 0 (device to memory), a moving word asserts mem_wr and drives mem_wdata with dev_rdata. With direction 1 (memory to device), it asserts mem_rd and drives dev_wdata with mem_rdata. The two strobes are never high together.
- R6: Each moved word adds 1 to the address register and subtracts 1 from the count register.
- R7: In cycle-stealing mode (burst bit 0), after every word except the last, bus_req is low for exactly one cycle and then rises again.
- R8: In burst mode, bus_req stays high without a break from the cycle after start until the cycle in which the last word moves.
- R9: In the cycle after the last word moves, bus_req and busy are 0, done is 1 and the count reads 0.
- R10: irq equals the interrupt-enable bit ANDed with (done OR error).
- R11: A start while the count is 0 sets error, clears done, and leaves busy and bus_req at 0.
- R12: A write to select 3 clears done where wdata bit 1 is 1 and clears error where wdata bit 2 is 1. A start that is accepted clears both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | REG_W | Register write data |
| cfg_rdata | output | REG_W | Read data of the selected register |
| irq | output | 1 | Interrupt request |
| bus_req | output | 1 | System bus request |
| bus_gnt | input | 1 | System bus grant |
| mem_addr | output | ADDR_W | Memory address of the moving word |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | DATA_W | Data written to memory |
| mem_rdata | input | DATA_W | Data read from memory (valid in the same cycle) |
| dev_ready | input | 1 | Device can accept or supply a word |
| dev_ack | output | 1 | Word moved this cycle |
| dev_rdata | input | DATA_W | Data supplied by the device |
| dev_wdata | output | DATA_W | Data delivered to the device |

## Verification
The bench keeps its own model of the address, count, mode and flags and compares every output in every cycle. If the count register is wrong, the block ends one word too early or too late. That shows up at once as a stray or a missing dev_ack and as a bus_req edge in the wrong cycle. If the address is wrong, mem_addr differs on the very next word. If a flag is wrong, irq and the status read-back differ in the first cycle after the fault. The grant pattern is varied, with grant delayed, always held and withheld. This exposes strobes that ignore the grant and a cycle-stealing gap whose length is wrong.

// File: rtl/dma_steal_pkg.sv
// Shared definitions for the block transfer engine.
// Assumes register selects and bit positions are fixed by software.
package dma_steal_pkg;
    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_RUN  = 2'd1,
        SQ_GAP  = 2'd2
    } seq_state_t;

    localparam logic [1:0] SEL_ADDR = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CTRL = 2'd2;
    localparam logic [1:0] SEL_STAT = 2'd3;

    localparam int CB_START = 0;
    localparam int CB_DIR   = 1;
    localparam int CB_BURST = 2;
    localparam int CB_IEN   = 3;

    localparam int SB_BUSY  = 0;
    localparam int SB_DONE  = 1;
    localparam int SB_ERR   = 2;
endpackage

// File: rtl/dma_regs.sv
// Programmable state: address, count, control bits and status flags.
// Assumes REG_W >= ADDR_W and REG_W >= CNT_W; writes to 0..2 ignored when busy.
module dma_regs
    import dma_steal_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              busy,
    input  logic              xfer,
    input  logic              finish,
    output logic              start_ok,
    output logic              cnt_last,
    output logic [ADDR_W-1:0] addr_q,
    output logic              dir_q,
    output logic              burst_q,
    output logic              ien_q,
    output logic              done_q,
    output logic              err_q,
    output logic [REG_W-1:0]  cfg_rdata
);
    logic [CNT_W-1:0] cnt_q;
    logic             wr_ok;
    logic             go;
    logic             zero_go;
    logic             clr_stat;

    // Decode register writes and the start command.
    always_comb begin
        wr_ok    = cfg_we && !busy;
        go       = wr_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CB_START];
        zero_go  = go && (cnt_q == '0);
        start_ok = go && (cnt_q != '0);
        clr_stat = cfg_we && (cfg_sel == SEL_STAT);
        cnt_last = (cnt_q == CNT_W'(1));
    end

    // Address register: loaded by software, advanced per moved word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            addr_q <= '0;
        else if (wr_ok && cfg_sel == SEL_ADDR)
            addr_q <= cfg_wdata[ADDR_W-1:0];
        else if (xfer)
            addr_q <= addr_q + ADDR_W'(1);
    end

    // Count register: loaded by software, reduced per moved word.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (wr_ok && cfg_sel == SEL_CNT)
            cnt_q <= cfg_wdata[CNT_W-1:0];
        else if (xfer)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // Control bits captured on an accepted control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q   <= 1'b0;
            burst_q <= 1'b0;
            ien_q   <= 1'b0;
        end else if (wr_ok && cfg_sel == SEL_CTRL) begin
            dir_q   <= cfg_wdata[CB_DIR];
            burst_q <= cfg_wdata[CB_BURST];
            ien_q   <= cfg_wdata[CB_IEN];
        end
    end

    // Done flag: set at block end, cleared by start or write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            done_q <= 1'b0;
        else if (finish)
            done_q <= 1'b1;
        else if (go)
            done_q <= 1'b0;
        else if (clr_stat && cfg_wdata[SB_DONE])
            done_q <= 1'b0;
    end

    // Error flag: set by a start with zero count.
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= 1'b0;
        else if (zero_go)
            err_q <= 1'b1;
        else if (go)
            err_q <= 1'b0;
        else if (clr_stat && cfg_wdata[SB_ERR])
            err_q <= 1'b0;
    end

    // Read-back multiplexer, zero-extended to the register width.
    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_ADDR: cfg_rdata = REG_W'(addr_q);
            SEL_CNT:  cfg_rdata = REG_W'(cnt_q);
            SEL_CTRL: begin
                cfg_rdata[CB_DIR]   = dir_q;
                cfg_rdata[CB_BURST] = burst_q;
                cfg_rdata[CB_IEN]   = ien_q;
            end
            default: begin
                cfg_rdata[SB_BUSY] = busy;
                cfg_rdata[SB_DONE] = done_q;
                cfg_rdata[SB_ERR]  = err_q;
            end
        endcase
    end
endmodule

// File: rtl/dma_seq.sv
// Sequencer: owns the bus request and decides when a word moves.
// Assumes a grant is only meaningful while the request is high.
module dma_seq
    import dma_steal_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start_ok,
    input  logic burst,
    input  logic cnt_last,
    input  logic bus_gnt,
    input  logic dev_ready,
    output logic busy,
    output logic bus_req,
    output logic xfer,
    output logic finish
);
    seq_state_t state_q, state_d;

    // Request, word-move and completion strobes from the current state.
    always_comb begin
        bus_req = (state_q == SQ_RUN);
        xfer    = bus_req && bus_gnt && dev_ready;
        finish  = xfer && cnt_last;
        busy    = (state_q != SQ_IDLE);
    end

    // Next-state selection for idle, holding and stealing phases.
    always_comb begin
        state_d = state_q;
        case (state_q)
            SQ_IDLE: if (start_ok) state_d = SQ_RUN;
            SQ_RUN: begin
                if (finish)
                    state_d = SQ_IDLE;
                else if (xfer && !burst)
                    state_d = SQ_GAP;
            end
            SQ_GAP:  state_d = SQ_RUN;
            default: state_d = SQ_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= SQ_IDLE;
        else
            state_q <= state_d;
    end
endmodule

// File: rtl/dma_port.sv
// Bus and device steering for the word moving in this cycle.
// Assumes memory read data is valid in the same cycle as the read strobe.
module dma_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              xfer,
    input  logic              dir,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic [DATA_W-1:0] dev_wdata,
    output logic              dev_ack
);
    // Drive the bus only for a moving word; otherwise keep it at zero.
    always_comb begin
        dev_ack   = xfer;
        mem_addr  = xfer ? addr : '0;
        mem_wr    = xfer && !dir;
        mem_rd    = xfer && dir;
        mem_wdata = (xfer && !dir) ? dev_rdata : '0;
        dev_wdata = (xfer && dir) ? mem_rdata : '0;
    end
endmodule

// File: rtl/dma_steal_ctrl.sv
// Top level of the single-channel block transfer engine.
// Assumes an external arbiter issues bus_gnt in response to bus_req.
module dma_steal_ctrl #(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 12,
    parameter int DATA_W = 16,
    parameter int REG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              irq,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              dev_ready,
    output logic              dev_ack,
    input  logic [DATA_W-1:0] dev_rdata,
    output logic [DATA_W-1:0] dev_wdata
);
    logic              busy_w;
    logic              xfer_w;
    logic              finish_w;
    logic              start_ok_w;
    logic              cnt_last_w;
    logic [ADDR_W-1:0] addr_w;
    logic              dir_w;
    logic              burst_w;
    logic              ien_w;
    logic              done_w;
    logic              err_w;

    dma_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .busy(busy_w), .xfer(xfer_w), .finish(finish_w),
        .start_ok(start_ok_w), .cnt_last(cnt_last_w), .addr_q(addr_w),
        .dir_q(dir_w), .burst_q(burst_w), .ien_q(ien_w),
        .done_q(done_w), .err_q(err_w), .cfg_rdata(cfg_rdata)
    );

    dma_seq u_seq (
        .clk(clk), .rst_n(rst_n),
        .start_ok(start_ok_w), .burst(burst_w), .cnt_last(cnt_last_w),
        .bus_gnt(bus_gnt), .dev_ready(dev_ready),
        .busy(busy_w), .bus_req(bus_req), .xfer(xfer_w), .finish(finish_w)
    );

    dma_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
        .xfer(xfer_w), .dir(dir_w), .addr(addr_w),
        .mem_rdata(mem_rdata), .dev_rdata(dev_rdata),
        .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_wdata(mem_wdata), .dev_wdata(dev_wdata), .dev_ack(dev_ack)
    );

    // Interrupt line from the enable bit and the two status flags.
    always_comb irq = ien_w && (done_w || err_w);
endmodule

// File: rtl/dma_steal_chk.sv
// Protocol checker for the block transfer engine, attached by bind.
// Assumes it observes the top module's ports and internal flags.
module dma_steal_chk (
    input logic clk,
    input logic rst_n,
    input logic bus_req,
    input logic bus_gnt,
    input logic mem_rd,
    input logic mem_wr,
    input logic dev_ack,
    input logic dev_ready,
    input logic busy,
    input logic burst,
    input logic done,
    input logic err
);
    p_gnt_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd || mem_wr || dev_ack) |-> (bus_gnt && bus_req));

    p_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dev_ack |-> dev_ready);

    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    p_steal_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_req) |=> bus_req);

    p_burst_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && burst && !dev_ack) |=> bus_req);

    p_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    p_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> (!busy && !bus_req));
endmodule

bind dma_steal_ctrl dma_steal_chk u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .dev_ack(dev_ack),
    .dev_ready(dev_ready), .busy(busy_w), .burst(burst_w),
    .done(done_w), .err(err_w)
);

// File: tb/dma_steal_ctrl_tb_top.sv
// Bench: behavioural reference model compared with every output each clock.
module dma_steal_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = 16'd0;
    logic [15:0] cfg_rdata;
    logic        irq, bus_req, mem_rd, mem_wr, dev_ack;
    logic        bus_gnt = 1'b0;
    logic        dev_ready = 1'b0;
    logic [15:0] mem_addr, mem_wdata, dev_wdata;
    logic [15:0] mem_rdata = 16'd0;
    logic [15:0] dev_rdata = 16'd0;

    int n_cmp = 0;
    int n_bad = 0;
    string tag = "R1";
    int gnt_mode = 0;   // 0 follows request one cycle late, 1 always, 2 never
    int rdy_mode = 0;   // 0 always ready, 1 alternating
    int cyc = 0;
    bit last_req = 1'b0;

    // model state
    bit m_busy = 0, m_gap = 0, m_dir = 0, m_burst = 0, m_ien = 0;
    bit m_done = 0, m_err = 0;
    int m_addr = 0, m_cnt = 0;

    dma_steal_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq(irq),
        .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .dev_ready(dev_ready), .dev_ack(dev_ack),
        .dev_rdata(dev_rdata), .dev_wdata(dev_wdata)
    );

    always #10 clk = ~clk;

    task automatic chk(string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s t=%0t actual=%0h expected=%0h", tag, what, $time, act, exp);
        end
    endtask

    function automatic bit m_xfer();
        return m_busy && !m_gap && bus_gnt && dev_ready;
    endfunction

    task automatic compare_all();
        bit x;
        int rd;
        x = m_xfer();
        chk("bus_req", int'(bus_req), int'(m_busy && !m_gap));
        chk("dev_ack", int'(dev_ack), int'(x));
        chk("mem_wr", int'(mem_wr), int'(x && !m_dir));
        chk("mem_rd", int'(mem_rd), int'(x && m_dir));
        chk("mem_addr", int'(mem_addr), x ? m_addr : 0);
        chk("mem_wdata", int'(mem_wdata), (x && !m_dir) ? int'(dev_rdata) : 0);
        chk("dev_wdata", int'(dev_wdata), (x && m_dir) ? int'(mem_rdata) : 0);
        chk("irq", int'(irq), int'(m_ien && (m_done || m_err)));
        case (cfg_sel)
            2'd0: rd = m_addr;
            2'd1: rd = m_cnt;
            2'd2: rd = (int'(m_ien) << 3) | (int'(m_burst) << 2) | (int'(m_dir) << 1);
            default: rd = (int'(m_err) << 2) | (int'(m_done) << 1) | int'(m_busy);
        endcase
        chk("cfg_rdata", int'(cfg_rdata), rd);
    endtask

    task automatic model_update();
        bit x, wr_ok, go;
        int oc;
        if (!rst_n) begin
            m_busy = 0; m_gap = 0; m_dir = 0; m_burst = 0; m_ien = 0;
            m_done = 0; m_err = 0; m_addr = 0; m_cnt = 0;
            return;
        end
        x = m_xfer();
        oc = m_cnt;
        wr_ok = cfg_we && !m_busy;
        go = wr_ok && cfg_sel == 2'd2 && cfg_wdata[0];
        if (wr_ok && cfg_sel == 2'd0) m_addr = int'(cfg_wdata);
        else if (x) m_addr = (m_addr + 1) & 16'hFFFF;
        if (wr_ok && cfg_sel == 2'd1) m_cnt = int'(cfg_wdata) & 12'hFFF;
        else if (x) m_cnt = (m_cnt - 1) & 12'hFFF;
        if (wr_ok && cfg_sel == 2'd2) begin
            m_dir = cfg_wdata[1]; m_burst = cfg_wdata[2]; m_ien = cfg_wdata[3];
        end
        if (go) begin
            m_done = 0;
            m_err = (oc == 0);
            if (oc != 0) begin m_busy = 1; m_gap = 0; end
        end else if (cfg_we && cfg_sel == 2'd3) begin
            if (cfg_wdata[1]) m_done = 0;
            if (cfg_wdata[2]) m_err = 0;
        end
        if (x) begin
            if (oc == 1) begin m_busy = 0; m_done = 1; end
            else if (!m_burst) m_gap = 1;
        end else if (m_gap) m_gap = 0;
    endtask

    // One clock: compare mid-cycle, update model at the edge, return at falling edge.
    task automatic tick();
        #1;
        if (rst_n) compare_all();
        last_req = bus_req;
        @(posedge clk);
        model_update();
        cyc++;
        @(negedge clk);
        cfg_we = 1'b0;
        bus_gnt = (gnt_mode == 1) ? 1'b1 : (gnt_mode == 2) ? 1'b0 : last_req;
        dev_ready = (rdy_mode == 0) ? 1'b1 : cyc[0];
        dev_rdata = 16'h5000 + 16'(cyc);
        mem_rdata = 16'hA000 ^ 16'(cyc * 3);
    endtask

    task automatic wr(logic [1:0] s, logic [15:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
        tick();
    endtask

    task automatic run(int n, logic [1:0] s);
        cfg_sel = s;
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(20 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk); @(negedge clk);
        model_update();
        rst_n = 1'b1;
        tag = "R1";
        for (int s = 0; s < 4; s++) run(1, 2'(s));

        tag = "R2";      // program and read back while idle
        wr(2'd0, 16'h0100);
        wr(2'd1, 16'd3);
        wr(2'd2, 16'h0008);
        for (int s = 0; s < 3; s++) run(1, 2'(s));

        tag = "R7";      // steal mode, device to memory, grant delayed
        gnt_mode = 0; rdy_mode = 1;
        wr(2'd2, 16'h0009);
        run(20, 2'd3);
        tag = "R9";
        run(2, 2'd1);
        tag = "R10";
        run(1, 2'd3);

        tag = "R12";
        wr(2'd3, 16'h0002);
        run(2, 2'd3);

        tag = "R8";      // burst mode, memory to device, busy writes ignored
        gnt_mode = 1; rdy_mode = 0;
        wr(2'd0, 16'hFFFE);
        wr(2'd1, 16'd5);
        wr(2'd2, 16'h0007);
        tag = "R2";
        wr(2'd0, 16'h1234);
        wr(2'd2, 16'h0001);
        tag = "R6";
        run(1, 2'd0);
        run(1, 2'd1);
        tag = "R8";
        run(6, 2'd3);

        tag = "R3";      // grant withheld: no strobes
        gnt_mode = 2;
        wr(2'd1, 16'd2);
        wr(2'd2, 16'h0001);
        run(5, 2'd3);
        tag = "R4";
        gnt_mode = 1; rdy_mode = 1;
        run(8, 2'd0);
        tag = "R5";
        run(2, 2'd3);

        tag = "R11";     // zero-count start
        wr(2'd2, 16'h0009);
        run(3, 2'd3);
        tag = "R12";
        wr(2'd3, 16'h0004);
        run(2, 2'd3);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule